// File: doc/BRIEF.md
# Real-Time Clock Interrupt Status Unit

This unit keeps the interrupt status of a real-time clock and drives its active-low interrupt line. Three single-cycle event strobes come in from neighbouring logic: a tick from the chosen divider tap, a hit from the alarm comparator, and a pulse when a time update has finished. Each strobe sets its own sticky flag whether or not its interrupt is enabled. Three static enable bits from the control register decide which flags may raise the interrupt.

Software reads the status through a small bus port. A read of the status register returns the request bit and the three flags, then clears the flags on the same clock edge that captures the data. A second read-only register reports a battery-good indication taken from an input pin. Writes to either address are taken and change nothing.

Top module: `rtc_irq_status`

## Requirements
- R1: A status read (`reg_sel` = 0) returns in `rd_data` bit 7 the request bit, bit 6 the periodic flag, bit 5 the alarm flag, bit 4 the update-done flag, and 0 in bits 3 to 0, one cycle after `rd_en` is sampled.
- R2: The request bit equals (periodic flag AND `per_en`) OR (alarm flag AND `alm_en`) OR (update flag AND `upd_en`).
- R3: `irq_n` is 0 exactly when the request bit formed from the flags and enables at the latest clock edge is 1, and is updated on that same edge.
- R4: An event strobe high at a clock edge sets its flag at that edge, whatever its enable bit holds.
- R5: A status read returns the flag values present before the read, and the flags clear on the edge that ends the read; the next status read returns 0x00 and `irq_n` returns to 1.
- R6: An event strobe at the same edge as a clearing status read leaves that flag at 1 after the read.
- R7: While `rst` is high at a clock edge all flags clear, `irq_n` goes to 1 and `rd_data` goes to 0x00.
- R8: A read with `reg_sel` = 1 returns bit 7 equal to `batt_ok` as sampled on the previous clock edge and 0 in bits 6 to 0; that sample is taken on every edge, reset included.
- R9: A write (`wr_en` high) to either address leaves all flags and `irq_n` unchanged.
- R10: A read with `reg_sel` = 1 does not clear the flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| per_evt | input | 1 | Periodic tap edge strobe |
| alm_evt | input | 1 | Alarm match strobe |
| upd_evt | input | 1 | Update-finished strobe |
| per_en | input | 1 | Periodic interrupt enable |
| alm_en | input | 1 | Alarm interrupt enable |
| upd_en | input | 1 | Update interrupt enable |
| batt_ok | input | 1 | Battery-good indication |
| rd_en | input | 1 | Bus read strobe |
| wr_en | input | 1 | Bus write strobe (no effect) |
| reg_sel | input | 1 | 0 selects status, 1 selects battery register |
| rd_data | output | 8 | Registered read data |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
An event strobe and a clearing status read can land on the same clock edge, and the set must win so no event is lost. The bench provokes this twice: once on a flag that was already set, and once on a flag that was clear before the read. It judges the outcome from the data of that read, which must show the old value, and from a second status read, which must still show the flag set.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int NUM_SRC = 3;
  localparam int IDX_UPD = 0;
  localparam int IDX_ALM = 1;
  localparam int IDX_PER = 2;

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_BATT   = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/rtc_flag_bank.sv
module rtc_flag_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] ev,
  input  logic         clr,
  output logic [N-1:0] flags_d,
  output logic [N-1:0] flags_q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    assign flags_d[i] = (flags_q[i] & ~clr) | ev[i];

    always_ff @(posedge clk) begin
      if (rst) flags_q[i] <= 1'b0;
      else     flags_q[i] <= flags_d[i];
    end

    // R4 and R6: a strobe always leaves its flag set
    a_r4_set: assert property (@(posedge clk) disable iff (rst)
      ev[i] |=> flags_q[i]);
    a_r6_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
      (ev[i] && clr) |=> flags_q[i]);
    a_r5_clear: assert property (@(posedge clk) disable iff (rst)
      (clr && !ev[i]) |=> !flags_q[i]);
    a_r7_reset_clear: assert property (@(posedge clk)
      rst |=> !flags_q[i]);
  end
endmodule

// File: rtl/rtc_req_comb.sv
module rtc_req_comb #(
  parameter int N = 3
) (
  input  logic [N-1:0] flags,
  input  logic [N-1:0] en,
  output logic         req
);
  always_comb req = |(flags & en);
endmodule

// File: rtl/rtc_rd_mux.sv
module rtc_rd_mux #(
  parameter int DATA_W = 8,
  parameter int N      = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              sel_batt,
  input  logic              req,
  input  logic [N-1:0]      flags,
  input  logic              bv,
  output logic [DATA_W-1:0] rd_data
);
  localparam int LOW_W = DATA_W - N - 1;

  logic [DATA_W-1:0] stat_word;
  logic [DATA_W-1:0] batt_word;

  always_comb begin
    stat_word = '0;
    stat_word[DATA_W-1] = req;
    stat_word[DATA_W-2 -: N] = flags;
    batt_word = '0;
    batt_word[DATA_W-1] = bv;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= sel_batt ? batt_word : stat_word;
  end

  a_r1_low_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !sel_batt) |=> (rd_data[LOW_W-1:0] == '0));
  a_r8_batt_low_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel_batt) |=> (rd_data[DATA_W-2:0] == '0));
endmodule

// File: rtl/rtc_irq_status.sv
module rtc_irq_status
  import rtc_irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              per_evt,
  input  logic              alm_evt,
  input  logic              upd_evt,
  input  logic              per_en,
  input  logic              alm_en,
  input  logic              upd_en,
  input  logic              batt_ok,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic              reg_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_n
);
  localparam int N = NUM_SRC;

  logic [N-1:0] ev_vec;
  logic [N-1:0] en_vec;
  logic [N-1:0] flags_d;
  logic [N-1:0] flags_q;
  logic         sel_batt;
  logic         rd_clr;
  logic         req_now;
  logic         req_nxt;
  logic         bv_q;

  always_comb begin
    ev_vec = '0;
    en_vec = '0;
    ev_vec[IDX_PER] = per_evt;
    ev_vec[IDX_ALM] = alm_evt;
    ev_vec[IDX_UPD] = upd_evt;
    en_vec[IDX_PER] = per_en;
    en_vec[IDX_ALM] = alm_en;
    en_vec[IDX_UPD] = upd_en;
  end

  assign sel_batt = (reg_sel_e'(reg_sel) == SEL_BATT);
  assign rd_clr   = rd_en && !sel_batt;

  rtc_flag_bank #(.N(N)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .ev      (ev_vec),
    .clr     (rd_clr),
    .flags_d (flags_d),
    .flags_q (flags_q)
  );

  rtc_req_comb #(.N(N)) u_req_now (
    .flags (flags_q),
    .en    (en_vec),
    .req   (req_now)
  );

  rtc_req_comb #(.N(N)) u_req_nxt (
    .flags (flags_d),
    .en    (en_vec),
    .req   (req_nxt)
  );

  // battery indication: sampled every edge, reset has no effect
  always_ff @(posedge clk) bv_q <= batt_ok;

  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else     irq_n <= ~req_nxt;
  end

  rtc_rd_mux #(.DATA_W(DATA_W), .N(N)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .sel_batt (sel_batt),
    .req      (req_now),
    .flags    (flags_q),
    .bv       (bv_q),
    .rd_data  (rd_data)
  );

  a_r3_irq_tracks_req: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_n == !(|(flags_q & $past(en_vec)))));
  a_r9_write_no_effect: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !rd_en && !(|ev_vec)) |=> $stable(flags_q));
  a_r10_batt_read_keeps: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel_batt && !(|ev_vec)) |=> $stable(flags_q));
  a_r7_reset_irq: assert property (@(posedge clk)
    rst |=> irq_n);
endmodule

// File: tb/rtc_irq_status_tb.sv
`timescale 1ns/1ps
module rtc_irq_status_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       per_evt = 0, alm_evt = 0, upd_evt = 0;
  logic       per_en = 0, alm_en = 0, upd_en = 0;
  logic       batt_ok = 1'b1;
  logic       rd_en = 0, wr_en = 0, reg_sel = 0;
  logic [7:0] rd_data;
  logic       irq_n;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  rtc_irq_status u_dut (
    .clk(clk), .rst(rst),
    .per_evt(per_evt), .alm_evt(alm_evt), .upd_evt(upd_evt),
    .per_en(per_en), .alm_en(alm_en), .upd_en(upd_en),
    .batt_ok(batt_ok), .rd_en(rd_en), .wr_en(wr_en), .reg_sel(reg_sel),
    .rd_data(rd_data), .irq_n(irq_n)
  );

  // {events(per,alm,upd), enables(per,alm,upd), expected request}
  localparam logic [6:0] VEC [8] = '{
    {3'b000, 3'b111, 1'b0},
    {3'b001, 3'b001, 1'b1},
    {3'b001, 3'b110, 1'b0},
    {3'b010, 3'b010, 1'b1},
    {3'b100, 3'b011, 1'b0},
    {3'b100, 3'b100, 1'b1},
    {3'b111, 3'b000, 1'b0},
    {3'b101, 3'b010, 1'b0}
  };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_ev(input logic [2:0] v);
    {per_evt, alm_evt, upd_evt} = v;
  endtask

  task automatic set_en(input logic [2:0] v);
    {per_en, alm_en, upd_en} = v;
  endtask

  task automatic do_read(input logic sel);
    reg_sel = sel; rd_en = 1'b1;
    tick();
    rd_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic run_vec(input logic [2:0] ev, input logic [2:0] en, input logic exp);
    do_read(1'b0);
    set_en(en); set_ev(ev);
    tick();
    set_ev(3'b000);
    chk({7'b0, irq_n}, {7'b0, ~exp}, "R3 irq_n after events");
    do_read(1'b0);
    chk(rd_data, {exp, ev, 4'b0000}, "R1 R2 R4 status byte");
    chk({7'b0, irq_n}, 8'h01, "R5 irq_n after clearing read");
    do_read(1'b0);
    chk(rd_data, 8'h00, "R5 flags cleared by read");
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    tick(); tick();
    chk({7'b0, irq_n}, 8'h01, "R7 irq_n in reset");
    chk(rd_data, 8'h00, "R7 rd_data in reset");
    rst = 1'b0;
    // R8: battery sampled through reset, readable in first cycle after
    do_read(1'b1);
    chk(rd_data, 8'h80, "R8 battery good after reset");

    for (int k = 0; k < 8; k++) run_vec(VEC[k][6:4], VEC[k][3:1], VEC[k][0]);
    for (int f = 0; f < 8; f++)
      for (int e = 0; e < 8; e++)
        run_vec(3'(f), 3'(e), |(3'(f) & 3'(e)));

    // R7: reset clears flags and releases irq_n
    set_en(3'b111); set_ev(3'b111); tick(); set_ev(3'b000);
    chk({7'b0, irq_n}, 8'h00, "R3 irq_n asserted before reset");
    rst = 1'b1; tick(); rst = 1'b0;
    chk({7'b0, irq_n}, 8'h01, "R7 irq_n after reset");
    do_read(1'b0);
    chk(rd_data, 8'h00, "R7 flags after reset");

    // R6: event during clearing read, flag already set
    set_en(3'b000);
    alm_evt = 1'b1; tick(); alm_evt = 1'b0;
    alm_evt = 1'b1; do_read(1'b0); alm_evt = 1'b0;
    chk(rd_data, 8'h20, "R6 read shows prior alarm flag");
    do_read(1'b0);
    chk(rd_data, 8'h20, "R6 alarm flag kept after read");
    // R6: event during read, flag previously clear
    per_evt = 1'b1; do_read(1'b0); per_evt = 1'b0;
    chk(rd_data, 8'h00, "R6 read shows pre-event value");
    do_read(1'b0);
    chk(rd_data, 8'h40, "R6 periodic flag kept");
    set_en(3'b100);
    chk({7'b0, irq_n}, 8'h01, "R3 irq_n high after clear");

    // R10: battery read keeps flags
    set_en(3'b001);
    upd_evt = 1'b1; tick(); upd_evt = 1'b0;
    do_read(1'b1);
    chk(rd_data, 8'h80, "R8 battery read value");
    chk({7'b0, irq_n}, 8'h00, "R10 irq_n held over battery read");
    do_read(1'b0);
    chk(rd_data, 8'h90, "R10 update flag survives battery read");

    // R9: writes change nothing
    upd_evt = 1'b1; tick(); upd_evt = 1'b0;
    wr_en = 1'b1; reg_sel = 1'b0; tick(); reg_sel = 1'b1; tick(); wr_en = 1'b0;
    chk({7'b0, irq_n}, 8'h00, "R9 irq_n after writes");
    do_read(1'b0);
    chk(rd_data, 8'h90, "R9 flags after writes");

    // R8: battery pin low
    batt_ok = 1'b0; tick();
    do_read(1'b1);
    chk(rd_data, 8'h00, "R8 battery bad");
    batt_ok = 1'b1; tick();
    do_read(1'b1);
    chk(rd_data, 8'h80, "R8 battery good again");

    finish_run();
  end
endmodule